// File: doc/BRIEF.md
# Direct-Mapped Page Translation Cache

This block caches page translations for a 32-bit memory-management unit. The caller hands it an effective address, an access kind, the virtual segment identifier already picked by segment lookup, and the protection key that applies in the current privilege state. The block answers with a real address or a fault code. A hit needs two matches: the stored segment identifier must equal the one presented, and the stored page bits must equal the page bits of the address. On a hit the block checks the access against the cached page-protection field. It then joins the cached real page number to the 12-bit byte offset.

On a miss the block asks an external table walker for the entry. The walker either supplies the entry, which is installed and then checked as on a hit, or reports that it found nothing. Each entry keeps the memory address of the second word of its page table entry. The first permitted data write to a page whose changed flag is clear reads that word through a single-outstanding request/grant memory port and writes it back with the changed bit set. Only then does the block answer.

Entries are never cleared. They are poisoned by writing an all-ones segment tag that no real identifier can equal. One entry can be poisoned at a time, and a sweep poisons all of them, both after reset and on request.

Top module: `pgxlat_cache`

## Requirements
- R1: A lookup hits only when the stored segment identifier equals `req_vsid` and the stored page bits equal `req_ea[27:12]`. The entry is selected by index `req_ea[17:12]`. The segment-select bits `req_ea[31:28]` take no part in the match. Any other lookup goes to the walker (`walk_req`).
- R2: A successful translation gives `rsp_ra = {real page number, req_ea[11:0]}` with `rsp_fault = 2'b00`. `rsp_valid` is a single-cycle pulse for each accepted request.
- R3: Protection uses the key bit, the 2-bit protection field and the kind (`2'b00` fetch, `2'b01` read, `2'b10` write; fetch and read count as reads). With key 0, everything is allowed except a write with field 3. With key 1, field 0 allows nothing, fields 1 and 3 allow reads only, and field 2 allows everything. A refused access gives fault `2'b01`.
- R4: Any faulting translation returns `rsp_ra` of all ones.
- R5: A permitted write to an entry whose changed flag is clear first reads the word at the stored address, with `mem_we = 0`. It then writes that word back with bit 7 set (bit 24 in big-endian numbering), with `mem_we = 1`. The response comes after the write is granted.
- R6: After that write-back the entry's changed flag is set, so later writes to that page make no memory access. Writes to a page that the walker reported as already changed make none either, and neither do reads or refused writes.
- R7: A one-cycle `inv_one` while idle poisons the entry at index `inv_ea[17:12]`. The next lookup at that index misses, whatever its page or segment. Other indices keep hitting.
- R8: A one-cycle `inv_all` while idle sweeps all 64 entries. `req_ready` stays low for 64 cycles after the cycle in which `inv_all` was seen, and every later lookup misses.
- R9: After reset all entries are invalid. `req_ready` stays low for 64 cycles, counting the cycle in which reset is released.
- R10: On a miss the block holds `walk_req`, with the stable address and segment identifier, until `walk_done`. A found entry (`walk_found = 1`) is installed and checked. A missing one gives fault `2'b10` and installs nothing, so the next identical lookup walks again.
- R11: While `mem_req` is high and `mem_gnt` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable. Only one memory transaction is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle and will accept a request this cycle |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write |
| req_vsid | input | 24 | Virtual segment identifier of the addressed segment |
| req_key | input | 1 | Segment protection key for the current privilege state |
| rsp_valid | output | 1 | Response pulse |
| rsp_ra | output | 32 | Real address, all ones on a fault |
| rsp_fault | output | 2 | 00 none, 01 protection, 10 table miss |
| inv_one | input | 1 | Poison the entry indexed by inv_ea |
| inv_all | input | 1 | Poison every entry |
| inv_ea | input | 32 | Address selecting the entry for inv_one |
| walk_req | output | 1 | Table walk request |
| walk_ea | output | 32 | Address being walked |
| walk_vsid | output | 24 | Segment identifier being walked |
| walk_done | input | 1 | Walker answer strobe |
| walk_found | input | 1 | Walker located an entry |
| walk_pp | input | 2 | Page protection field |
| walk_chg | input | 1 | Changed flag as found in memory |
| walk_rpn | input | 20 | Real page number |
| walk_pte1 | input | 32 | Byte address of the second page table word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Grant; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest state to reach is a write that hits a resident entry whose changed flag is still clear. It only arises when an earlier read, or a refused write, installed the entry from a walker reply marked unchanged. The bench reaches it by building page addresses whose bit 25 sets the walker's changed answer and whose bits 27:26 set the protection field. It reads a clean page first, then writes it twice, and counts memory transactions each time. Stale-entry replacement is reached the same way: a second segment identifier is sent at an index that already holds a hit, and then the first one is sent again.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam logic [1:0] ACC_FETCH = 2'b00;
  localparam logic [1:0] ACC_READ  = 2'b01;
  localparam logic [1:0] ACC_WRITE = 2'b10;

  localparam logic [1:0] FLT_NONE = 2'b00;
  localparam logic [1:0] FLT_PROT = 2'b01;
  localparam logic [1:0] FLT_MISS = 2'b10;

  typedef enum logic [2:0] {
    S_SWEEP, S_IDLE, S_LOOK, S_WALK, S_CHECK, S_MRD, S_MWR
  } pgx_state_e;

  // key 0: all but write to field 3; key 1: 0 none, 2 all, 1/3 read only
  function automatic logic pgx_allowed(input logic key, input logic [1:0] pp,
                                       input logic is_wr);
    if (!key) return !(pp == 2'b11 && is_wr);
    case (pp)
      2'b00:   return 1'b0;
      2'b10:   return 1'b1;
      default: return !is_wr;
    endcase
  endfunction
endpackage

// File: rtl/pgx_entry_ram.sv
module pgx_entry_ram #(
  parameter int W  = 88,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pgx_tag_match.sv
module pgx_tag_match #(
  parameter int VSID_W = 24,
  parameter int HI_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VSID_W:0]   ent_tag,
  input  logic [HI_W-1:0]   ent_hi,
  input  logic [VSID_W-1:0] vsid,
  input  logic [HI_W-1:0]   ea_hi,
  output logic              hit
);
  // the extra tag bit is zero for live entries, so all ones never matches
  assign hit = (ent_tag == {1'b0, vsid}) && (ent_hi == ea_hi);

  assert_poison_nohit_R7: assert property (@(posedge clk) disable iff (rst)
    (ent_tag == '1) |-> !hit);
endmodule

// File: rtl/pgx_prot_check.sv
module pgx_prot_check (
  input  logic       key,
  input  logic [1:0] pp,
  input  logic [1:0] kind,
  output logic       ok
);
  import pgx_pkg::*;
  always_comb ok = pgx_allowed(key, pp, kind == ACC_WRITE);
endmodule

// File: rtl/pgxlat_cache.sv
module pgxlat_cache #(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int PAGE_W  = 16,
  parameter int IDX_W   = 6,
  parameter int VSID_W  = 24,
  parameter int CHG_BIT = 7
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_ea,
  input  logic [1:0]              req_kind,
  input  logic [VSID_W-1:0]       req_vsid,
  input  logic                    req_key,
  output logic                    rsp_valid,
  output logic [ADDR_W-1:0]       rsp_ra,
  output logic [1:0]              rsp_fault,
  input  logic                    inv_one,
  input  logic                    inv_all,
  input  logic [ADDR_W-1:0]       inv_ea,
  output logic                    walk_req,
  output logic [ADDR_W-1:0]       walk_ea,
  output logic [VSID_W-1:0]       walk_vsid,
  input  logic                    walk_done,
  input  logic                    walk_found,
  input  logic [1:0]              walk_pp,
  input  logic                    walk_chg,
  input  logic [ADDR_W-OFF_W-1:0] walk_rpn,
  input  logic [ADDR_W-1:0]       walk_pte1,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ADDR_W-1:0]       mem_wdata,
  input  logic                    mem_gnt,
  input  logic [ADDR_W-1:0]       mem_rdata
);
  import pgx_pkg::*;

  localparam int RPN_W = ADDR_W - OFF_W;
  localparam int HI_W  = PAGE_W - IDX_W;
  localparam int PTW_W = ADDR_W - 2;

  typedef struct packed {
    logic [VSID_W:0] tag;
    logic [HI_W-1:0] hi;
    logic [1:0]      pp;
    logic            chg;
    logic [RPN_W-1:0] rpn;
    logic [PTW_W-1:0] ptw;
  } ent_t;

  localparam int ENT_W = $bits(ent_t);
  localparam ent_t POISON = '{tag: '1, default: '0};

  pgx_state_e       state;
  logic [IDX_W-1:0] sweep_idx;
  logic [ADDR_W-1:0] cur_ea;
  logic [1:0]       cur_kind;
  logic [VSID_W-1:0] cur_vsid;
  logic             cur_key;
  ent_t             cur_ent;
  ent_t             rd_ent, wr_ent, fill_ent;
  logic             ram_we, ram_re;
  logic [IDX_W-1:0] ram_waddr;
  logic             hit, prot_ok, is_wr;
  logic [IDX_W-1:0] cur_idx;

  assign cur_idx   = cur_ea[OFF_W +: IDX_W];
  assign is_wr     = (cur_kind == ACC_WRITE);
  assign req_ready = (state == S_IDLE) && !inv_one && !inv_all;
  assign ram_re    = req_ready && req_valid;

  assign walk_req  = (state == S_WALK);
  assign walk_ea   = cur_ea;
  assign walk_vsid = cur_vsid;
  assign mem_req   = (state == S_MRD) || (state == S_MWR);
  assign mem_we    = (state == S_MWR);
  assign mem_addr  = {cur_ent.ptw, 2'b00};

  always_comb begin
    fill_ent.tag = {1'b0, cur_vsid};
    fill_ent.hi  = cur_ea[OFF_W+IDX_W +: HI_W];
    fill_ent.pp  = walk_pp;
    fill_ent.chg = walk_chg;
    fill_ent.rpn = walk_rpn;
    fill_ent.ptw = walk_pte1[ADDR_W-1:2];
  end

  pgx_entry_ram #(.W(ENT_W), .AW(IDX_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(wr_ent),
    .re(ram_re), .raddr(req_ea[OFF_W +: IDX_W]), .rdata(rd_ent)
  );

  pgx_tag_match #(.VSID_W(VSID_W), .HI_W(HI_W)) u_match (
    .clk(clk), .rst(rst), .ent_tag(rd_ent.tag), .ent_hi(rd_ent.hi),
    .vsid(cur_vsid), .ea_hi(cur_ea[OFF_W+IDX_W +: HI_W]), .hit(hit)
  );

  pgx_prot_check u_prot (
    .key(cur_key), .pp(cur_ent.pp), .kind(cur_kind), .ok(prot_ok)
  );

  // single write port shared by sweep, single poison, refill and changed update
  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = cur_idx;
    wr_ent    = cur_ent;
    case (state)
      S_SWEEP: begin
        ram_we = 1'b1; ram_waddr = sweep_idx; wr_ent = POISON;
      end
      S_IDLE: if (inv_one && !inv_all) begin
        ram_we = 1'b1; ram_waddr = inv_ea[OFF_W +: IDX_W]; wr_ent = POISON;
      end
      S_WALK: if (walk_done && walk_found) begin
        ram_we = 1'b1; wr_ent = fill_ent;
      end
      S_MWR: if (mem_gnt) begin
        ram_we = 1'b1; wr_ent.chg = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_SWEEP;
      sweep_idx <= '0;
      rsp_valid <= 1'b0;
      rsp_ra    <= '0;
      rsp_fault <= FLT_NONE;
      mem_wdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_SWEEP: begin
          sweep_idx <= sweep_idx + 1'b1;
          if (sweep_idx == '1) state <= S_IDLE;
        end
        S_IDLE: begin
          if (inv_all) begin
            state     <= S_SWEEP;
            sweep_idx <= '0;
          end else if (!inv_one && req_valid) begin
            cur_ea   <= req_ea;
            cur_kind <= req_kind;
            cur_vsid <= req_vsid;
            cur_key  <= req_key;
            state    <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (hit) begin
            cur_ent <= rd_ent;
            state   <= S_CHECK;
          end else begin
            state <= S_WALK;
          end
        end
        S_WALK: if (walk_done) begin
          if (walk_found) begin
            cur_ent <= fill_ent;
            state   <= S_CHECK;
          end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= FLT_MISS;
            rsp_ra    <= '1;
            state     <= S_IDLE;
          end
        end
        S_CHECK: begin
          if (!prot_ok) begin
            rsp_valid <= 1'b1;
            rsp_fault <= FLT_PROT;
            rsp_ra    <= '1;
            state     <= S_IDLE;
          end else if (is_wr && !cur_ent.chg) begin
            state <= S_MRD;
          end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= FLT_NONE;
            rsp_ra    <= {cur_ent.rpn, cur_ea[OFF_W-1:0]};
            state     <= S_IDLE;
          end
        end
        S_MRD: if (mem_gnt) begin
          mem_wdata <= mem_rdata | (ADDR_W'(1) << CHG_BIT);
          state     <= S_MWR;
        end
        S_MWR: if (mem_gnt) begin
          cur_ent.chg <= 1'b1;
          rsp_valid   <= 1'b1;
          rsp_fault   <= FLT_NONE;
          rsp_ra      <= {cur_ent.rpn, cur_ea[OFF_W-1:0]};
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_rsp_single_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_fault_ra_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_ra == '1));
  assert_wbit_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[CHG_BIT]);
  assert_clean_only_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (cur_kind == ACC_WRITE && !cur_ent.chg));
  assert_walk_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !walk_done) |=> (walk_req && $stable(walk_ea) && $stable(walk_vsid)));
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/tb_pgxlat_cache.sv
module tb_pgxlat_cache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_ready, req_key = 0;
  logic [31:0] req_ea = 0;
  logic [1:0]  req_kind = 0;
  logic [23:0] req_vsid = 0;
  logic        rsp_valid;
  logic [31:0] rsp_ra;
  logic [1:0]  rsp_fault;
  logic        inv_one = 0, inv_all = 0;
  logic [31:0] inv_ea = 0;
  logic        walk_req, walk_done = 0, walk_found = 0, walk_chg = 0;
  logic [31:0] walk_ea, walk_pte1 = 0;
  logic [23:0] walk_vsid;
  logic [1:0]  walk_pp = 0;
  logic [19:0] walk_rpn = 0;
  logic        mem_req, mem_we, mem_gnt = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;

  int n_chk = 0, n_fail = 0;
  int walk_cnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_waddr = 0, last_wdata = 0;

  pgxlat_cache dut (.*);

  function automatic logic [19:0] m_rpn(logic [31:0] ea, logic [23:0] vs);
    return {4'h0, ea[27:12]} ^ vs[19:0];
  endfunction
  function automatic logic [31:0] m_pte1(logic [31:0] ea);
    return 32'h4000_0004 | ({16'h0, ea[27:12]} << 3);
  endfunction
  function automatic logic [31:0] m_rd(logic [31:0] a);
    return (a ^ 32'h1357_0000) & ~32'h80;
  endfunction
  function automatic logic m_ok(logic key, logic [1:0] pp, logic [1:0] kind);
    logic w;
    w = (kind == 2'b10);
    if (key == 1'b0) return (pp == 2'b11) ? !w : 1'b1;
    if (pp == 2'b00) return 1'b0;
    if (pp == 2'b10) return 1'b1;
    return !w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // table walker model: pp from ea[27:26], changed from ea[25]
  initial forever begin
    @(negedge clk);
    if (walk_req) begin
      @(negedge clk);
      walk_cnt++;
      walk_found = (walk_vsid[23:20] != 4'hF);
      walk_pp    = walk_ea[27:26];
      walk_chg   = walk_ea[25];
      walk_rpn   = m_rpn(walk_ea, walk_vsid);
      walk_pte1  = m_pte1(walk_ea);
      walk_done  = 1'b1;
      @(negedge clk);
      walk_done  = 1'b0;
    end
  end

  // memory model
  initial forever begin
    @(negedge clk);
    if (mem_req) begin
      @(negedge clk);
      if (mem_we) begin
        wr_cnt++; last_waddr = mem_addr; last_wdata = mem_wdata;
      end else begin
        rd_cnt++; mem_rdata = m_rd(mem_addr);
      end
      mem_gnt = 1'b1;
      @(negedge clk);
      mem_gnt = 1'b0;
    end
  end

  task automatic xlat(input logic [31:0] ea, input logic [1:0] kind, input logic [23:0] vs,
                      input logic key, input bit exp_hit, input int exp_wb, input string tag);
    int w0, r0, wr0, guard;
    logic [1:0]  ef;
    logic [31:0] era;
    w0 = walk_cnt; r0 = rd_cnt; wr0 = wr_cnt;
    if (!exp_hit && vs[23:20] == 4'hF) ef = 2'b10;
    else if (!m_ok(key, ea[27:26], kind)) ef = 2'b01;
    else ef = 2'b00;
    era = (ef != 2'b00) ? 32'hFFFF_FFFF : {m_rpn(ea, vs), ea[11:0]};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_ea = ea; req_kind = kind; req_vsid = vs; req_key = key; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 500) begin @(negedge clk); guard++; end
    chk(rsp_valid, {tag, " R2 response"}, 32'(rsp_valid), 32'd1);
    chk(rsp_fault == ef, {tag, " R3/R4 fault"}, 32'(rsp_fault), 32'(ef));
    chk(rsp_ra == era, {tag, " R2/R4 ra"}, rsp_ra, era);
    chk((walk_cnt - w0) == (exp_hit ? 0 : 1), {tag, " R1/R10 walk"}, 32'(walk_cnt - w0), exp_hit ? 32'd0 : 32'd1);
    chk((wr_cnt - wr0) == exp_wb && (rd_cnt - r0) == exp_wb, {tag, " R5/R6 mem traffic"},
        32'(wr_cnt - wr0), 32'(exp_wb));
    if (exp_wb != 0) begin
      chk(last_waddr == m_pte1(ea), {tag, " R5 write addr"}, last_waddr, m_pte1(ea));
      chk(last_wdata == (m_rd(m_pte1(ea)) | 32'h80), {tag, " R5 write data"},
          last_wdata, m_rd(m_pte1(ea)) | 32'h80);
    end
  endtask

  function automatic logic [31:0] mk_ea(logic [9:0] hi, int idx, logic [11:0] off);
    return {4'h0, hi, 6'(idx), off};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int cnt;
    // R9: reset sweep
    repeat (3) @(negedge clk);
    chk(!req_ready && !rsp_valid && !mem_req && !walk_req, "R9 reset outputs", 32'(req_ready), 32'd0);
    rst = 1'b0;
    cnt = 0;
    while (!req_ready && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(cnt == 64, "R9 reset busy cycles", 32'(cnt), 32'd64);

    // R1/R2/R10: miss then hit over every index
    for (int i = 0; i < 64; i++) begin
      xlat(mk_ea(10'h2A5, i, 12'(i * 37)), 2'b01, 24'h012345, 1'b0, 1'b0, 0, "R10 sweep miss");
      xlat(mk_ea(10'h2A5, i, 12'(i * 53 + 1)), 2'b01, 24'h012345, 1'b0, 1'b1, 0, "R1 sweep hit");
    end
    // R1: segment select bits ignored, other vsid or page misses
    xlat(32'h7000_0000 | mk_ea(10'h2A5, 3, 12'h111), 2'b00, 24'h012345, 1'b0, 1'b1, 0, "R1 seg bits ignored");
    xlat(mk_ea(10'h2A5, 3, 12'h222), 2'b01, 24'h054321, 1'b0, 1'b0, 0, "R1 other vsid");
    xlat(mk_ea(10'h2A5, 3, 12'h333), 2'b01, 24'h012345, 1'b0, 1'b0, 0, "R1 replaced entry");
    xlat(mk_ea(10'h2B5, 3, 12'h444), 2'b01, 24'h012345, 1'b0, 1'b0, 0, "R1 other page");
    xlat(mk_ea(10'h2A5, 3, 12'h555), 2'b01, 24'h012345, 1'b0, 1'b0, 0, "R1 page replaced");

    // R3: full protection table, changed pages so no write-back
    for (int key = 0; key < 2; key++)
      for (int pp = 0; pp < 4; pp++)
        for (int kind = 0; kind < 3; kind++) begin
          int c;
          c = key * 12 + pp * 3 + kind;
          xlat(mk_ea({2'(pp), 1'b1, 7'h11}, c, 12'h0F0), 2'(kind), 24'h0A0B0C, 1'(key), 1'b0, 0, "R3 prot miss");
          xlat(mk_ea({2'(pp), 1'b1, 7'h11}, c, 12'h0F4), 2'(kind), 24'h0A0B0C, 1'(key), 1'b1, 0, "R3 prot hit");
        end

    // R5/R6: changed-bit write-back
    xlat(mk_ea({2'b10, 1'b0, 7'h05}, 40, 12'h010), 2'b10, 24'h00BEEF, 1'b0, 1'b0, 1, "R5 write miss clean");
    xlat(mk_ea({2'b10, 1'b0, 7'h05}, 40, 12'h014), 2'b10, 24'h00BEEF, 1'b0, 1'b1, 0, "R6 second write");
    xlat(mk_ea({2'b10, 1'b0, 7'h05}, 40, 12'h018), 2'b01, 24'h00BEEF, 1'b0, 1'b1, 0, "R6 read after");
    xlat(mk_ea({2'b10, 1'b0, 7'h06}, 41, 12'h020), 2'b01, 24'h00BEEF, 1'b0, 1'b0, 0, "R6 read clean");
    xlat(mk_ea({2'b10, 1'b0, 7'h06}, 41, 12'h024), 2'b10, 24'h00BEEF, 1'b0, 1'b1, 1, "R5 write hit clean");
    xlat(mk_ea({2'b10, 1'b0, 7'h06}, 41, 12'h028), 2'b10, 24'h00BEEF, 1'b0, 1'b1, 0, "R6 write after wb");
    xlat(mk_ea({2'b01, 1'b0, 7'h07}, 42, 12'h030), 2'b10, 24'h00BEEF, 1'b1, 1'b0, 0, "R6 refused write");

    // R10/R4: walker finds nothing
    xlat(mk_ea(10'h2A5, 50, 12'h040), 2'b01, 24'hF00001, 1'b0, 1'b0, 0, "R10 not found");
    xlat(mk_ea(10'h2A5, 50, 12'h044), 2'b01, 24'hF00001, 1'b0, 1'b0, 0, "R10 not installed");

    // R7: single poison
    xlat(mk_ea(10'h2A5, 5, 12'h050), 2'b01, 24'h111111, 1'b0, 1'b0, 0, "R7 setup 5");
    xlat(mk_ea(10'h2A5, 6, 12'h060), 2'b01, 24'h111111, 1'b0, 1'b0, 0, "R7 setup 6");
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    inv_ea = mk_ea(10'h3FF, 5, 12'hFFF); inv_one = 1'b1;
    @(negedge clk);
    inv_one = 1'b0;
    xlat(mk_ea(10'h2A5, 5, 12'h054), 2'b01, 24'h111111, 1'b0, 1'b0, 0, "R7 poisoned miss");
    xlat(mk_ea(10'h2A5, 6, 12'h064), 2'b01, 24'h111111, 1'b0, 1'b1, 0, "R7 neighbour hit");

    // R8: poison all
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    inv_all = 1'b1;
    #0.1 chk(!req_ready, "R8 ready low with inv_all", 32'(req_ready), 32'd0);
    @(negedge clk);
    inv_all = 1'b0;
    cnt = 0;
    while (!req_ready && cnt < 1000) begin cnt++; @(negedge clk); end
    chk(cnt == 64, "R8 sweep busy cycles", 32'(cnt), 32'd64);
    xlat(mk_ea(10'h2A5, 6, 12'h068), 2'b01, 24'h111111, 1'b0, 1'b0, 0, "R8 miss after sweep");
    xlat(mk_ea({2'b10, 1'b0, 7'h06}, 41, 12'h02C), 2'b01, 24'h00BEEF, 1'b0, 1'b0, 0, "R8 miss after sweep b");
    xlat(mk_ea(10'h2A5, 10, 12'h070), 2'b01, 24'h012345, 1'b0, 1'b0, 0, "R8 miss after sweep c");

    finish_run();
  end
endmodule